// File: doc/BRIEF.md
# SPI Status Polling Engine

This block is an SPI master that repeatedly reads a one-byte status word from an attached target until the target reports that it is idle. A client sequencer pulses a start request together with an 8-bit ready-mask. The engine then issues status-read transactions and decodes the busy, ready and error flags. It finishes with a one-cycle done strobe, a two-bit result code and the final status byte.

Each status sample is built from two identical one-byte transactions, with chip-select released between them. The first returned byte is discarded and only the second is used. The sample loop is bounded by a retry limit.

The byte shifter runs in SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. Its clock divider is fixed by a parameter. Multi-byte transfers and any higher-level command sequencing belong to the client.

Top module: `stpoll_top`

## Requirements
- R1: Each transaction holds `cs_n_o` low for exactly 8 rising edges of `sclk_o`. `sclk_o` stays low while `cs_n_o` is high. `mosi_o` carries the status-read opcode 0x00, most significant bit first. The byte on `miso_i` is sampled on the rising `sclk_o` edges.
- R2: Each status sample consists of two transactions. The byte received in the first is ignored, and the sample is the byte received in the second. A poll that ends after N samples performs exactly 2N transactions.
- R3: Before every transaction, `cs_n_o` stays high for at least CS_GAP full SPI clock periods, which is CS_GAP*2*HALF system clocks.
- R4: If sample bit 2 (protocol violation) or bit 3 (transfer error) is set, the poll ends at that sample with result 1 (I/O error). This takes priority over every other bit.
- R5: If sample bit 0 (busy) is set and no error bit is set, the engine takes another sample.
- R6: If busy is clear and the latched mask is zero, the poll ends with result 0 (success).
- R7: If busy is clear and the mask is non-zero, the poll succeeds only when the sample ANDed with the mask is non-zero. Otherwise the engine takes another sample. Bit 1 is the ready flag normally placed in the mask.
- R8: If MAX_TRIES samples are taken without success or error, the poll ends with result 2 (timeout).
- R9: The poll ends with `done_o` high for exactly one cycle. From that cycle until the next completion, `status_o` holds the final sample and `res_o` holds the result.
- R10: `mask_i` is latched when a start is accepted. A `start_i` pulse is accepted only while no poll is running. Pulses during a poll change neither the mask nor the transaction count.
- R11: After reset, `cs_n_o` is 1, `sclk_o` is 0, `done_o` is 0, `status_o` is 0 and `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Poll request pulse |
| mask_i | input | 8 | Ready-mask; zero means that busy-clear alone succeeds |
| done_o | output | 1 | One-cycle completion strobe |
| res_o | output | 2 | 0 success, 1 I/O error, 2 timeout |
| status_o | output | 8 | Final status sample |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_n_o | output | 1 | SPI chip-select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench sweeps every low-six-bit status value against several masks. It includes error bits together with busy, which a design that tested busy first would retry instead of failing. In the first transaction of every pair, the bench's target returns a byte with both error bits set, so a design that used that byte would fail every poll. Busy runs of 0 to MAX_TRIES samples probe the retry boundary: an off-by-one counter times out one sample early or takes one extra sample, and that changes the transaction count. A stray start with a contradicting mask during a running poll would turn a success into a timeout if it were accepted.

// File: rtl/stpoll_pkg.sv
// Shared types for the SPI status polling engine.
// Assumes: status byte bit 0 busy, bit 2 violation, bit 3 transfer error.
package stpoll_pkg;
    localparam logic [7:0] OPC_STATUS = 8'h00;
    localparam int ST_BUSY = 0;
    localparam int ST_VIOL = 2;
    localparam int ST_XERR = 3;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_IOERR = 2'd1,
        RES_TMO   = 2'd2
    } poll_res_e;

    typedef enum logic [1:0] {
        V_PASS  = 2'd0,
        V_FAIL  = 2'd1,
        V_AGAIN = 2'd2,
        V_TMO   = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_GAP  = 2'd1,
        C_XFER = 2'd2
    } ctrl_st_e;
endpackage

// File: rtl/stpoll_shifter.sv
// One-byte SPI mode-0 shifter. Holds chip-select low for a single byte.
// Assumes: go_i only arrives while idle; HALF system clocks per SCLK half period.
module stpoll_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       sclk_o,
    output logic       cs_n_o,
    output logic       mosi_o
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

    logic          act_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic          sclk_q;
    logic          done_q;

    // Byte shift sequencing: sample on rising SCLK, advance on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (go_i) begin
                    act_q  <= 1'b1;
                    tx_q   <= tx_i;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q != DIV_LAST) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso_i};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign done_o = done_q;
    assign rx_o   = rx_q;
    assign sclk_o = sclk_q;
    assign cs_n_o = ~act_q;
    assign mosi_o = act_q & tx_q[7];

    p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o) else $error("sclk high while deselected");
    p_done_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o) else $error("done while selected");
endmodule

// File: rtl/stpoll_judge.sv
// Decides what to do with one status sample: pass, fail, retry or time out.
// Assumes: error bits outrank busy; last_i marks the final permitted sample.
module stpoll_judge (
    input  logic [7:0]          sample_i,
    input  logic [7:0]          mask_i,
    input  logic                last_i,
    output stpoll_pkg::verdict_e verdict_o
);
    import stpoll_pkg::*;

    logic err_w;
    logic idle_ok_w;

    // Classify the sample by error, busy and mask match.
    always_comb begin
        err_w     = sample_i[ST_VIOL] | sample_i[ST_XERR];
        idle_ok_w = !sample_i[ST_BUSY] && ((mask_i == 8'h00) || ((sample_i & mask_i) != 8'h00));
        if (err_w)          verdict_o = V_FAIL;
        else if (idle_ok_w) verdict_o = V_PASS;
        else if (last_i)    verdict_o = V_TMO;
        else                verdict_o = V_AGAIN;
    end
endmodule

// File: rtl/stpoll_ctrl.sv
// Poll sequencer: chip-select gap, paired transactions, retry counting, result.
// Assumes: shifter pulses sh_done_i once per go_o; verdict_i judges sh_rx_i.
module stpoll_ctrl #(
    parameter int HALF      = 2,
    parameter int MAX_TRIES = 10000,
    parameter int CS_GAP    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [7:0]           mask_i,
    input  logic                 sh_done_i,
    input  logic [7:0]           sh_rx_i,
    input  logic                 cs_n_i,
    input  stpoll_pkg::verdict_e verdict_i,
    output logic [7:0]           mask_o,
    output logic                 last_o,
    output logic                 go_o,
    output logic                 done_o,
    output logic [1:0]           res_o,
    output logic [7:0]           status_o
);
    import stpoll_pkg::*;

    localparam int GAP_CYC = CS_GAP * 2 * HALF;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int TW      = $clog2(MAX_TRIES + 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
    localparam logic [TW-1:0] TRY_LAST  = TW'(MAX_TRIES - 1);

    ctrl_st_e      st_q;
    logic [GW-1:0] gap_q;
    logic [TW-1:0] tries_q;
    logic          second_q;
    logic [7:0]    mask_q;
    logic          go_q;
    logic          done_q;
    poll_res_e     res_q;
    logic [7:0]    stat_q;
    logic [GW-1:0] hi_q;

    // Main poll state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= C_IDLE;
            gap_q    <= '0;
            tries_q  <= '0;
            second_q <= 1'b0;
            mask_q   <= '0;
            go_q     <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= RES_OK;
            stat_q   <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (st_q)
                C_IDLE: if (start_i) begin
                    mask_q   <= mask_i;
                    tries_q  <= '0;
                    second_q <= 1'b0;
                    gap_q    <= '0;
                    st_q     <= C_GAP;
                end
                C_GAP: if (gap_q == GAP_LAST) begin
                    go_q <= 1'b1;
                    st_q <= C_XFER;
                end else begin
                    gap_q <= gap_q + 1'b1;
                end
                C_XFER: if (sh_done_i) begin
                    gap_q <= '0;
                    if (!second_q) begin
                        second_q <= 1'b1;
                        st_q     <= C_GAP;
                    end else if (verdict_i == V_AGAIN) begin
                        second_q <= 1'b0;
                        tries_q  <= tries_q + 1'b1;
                        st_q     <= C_GAP;
                    end else begin
                        done_q <= 1'b1;
                        stat_q <= sh_rx_i;
                        st_q   <= C_IDLE;
                        case (verdict_i)
                            V_PASS:  res_q <= RES_OK;
                            V_FAIL:  res_q <= RES_IOERR;
                            default: res_q <= RES_TMO;
                        endcase
                    end
                end
                default: st_q <= C_IDLE;
            endcase
        end
    end

    // Saturating count of cycles with chip-select high, for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_q <= '0;
        else if (!cs_n_i)             hi_q <= '0;
        else if (hi_q != GW'(GAP_CYC)) hi_q <= hi_q + 1'b1;
    end

    assign mask_o   = mask_q;
    assign last_o   = (tries_q == TRY_LAST);
    assign go_o     = go_q;
    assign done_o   = done_q;
    assign res_o    = res_q;
    assign status_o = stat_q;

    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_i) |-> (hi_q >= GW'(GAP_CYC))) else $error("chip-select gap too short");
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done wider than one cycle");
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != C_IDLE) |=> $stable(mask_q)) else $error("mask changed mid-poll");
    p_try_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q < TW'(MAX_TRIES)) else $error("retry count past limit");
    p_err_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (status_o[ST_VIOL] || status_o[ST_XERR])) |-> (res_o == RES_IOERR))
        else $error("error bit without I/O error result");
    p_go_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> cs_n_i) else $error("go while selected");
endmodule

// File: rtl/stpoll_top.sv
// SPI status polling engine top: sequencer, sample judge and mode-0 shifter.
// Assumes: HALF >= 1, MAX_TRIES >= 1, CS_GAP >= 1.
module stpoll_top #(
    parameter int HALF      = 2,
    parameter int MAX_TRIES = 10000,
    parameter int CS_GAP    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] mask_i,
    output logic       done_o,
    output logic [1:0] res_o,
    output logic [7:0] status_o,
    output logic       sclk_o,
    output logic       cs_n_o,
    output logic       mosi_o,
    input  logic       miso_i
);
    import stpoll_pkg::*;

    logic       go_w;
    logic       sh_done_w;
    logic [7:0] rx_w;
    logic [7:0] mask_w;
    logic       last_w;
    logic       cs_n_w;
    verdict_e   verdict_w;

    stpoll_ctrl #(.HALF(HALF), .MAX_TRIES(MAX_TRIES), .CS_GAP(CS_GAP)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .sh_done_i(sh_done_w), .sh_rx_i(rx_w), .cs_n_i(cs_n_w),
        .verdict_i(verdict_w), .mask_o(mask_w), .last_o(last_w), .go_o(go_w),
        .done_o(done_o), .res_o(res_o), .status_o(status_o)
    );

    stpoll_judge u_judge (
        .sample_i(rx_w), .mask_i(mask_w), .last_i(last_w), .verdict_o(verdict_w)
    );

    stpoll_shifter #(.HALF(HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .go_i(go_w), .tx_i(OPC_STATUS), .miso_i(miso_i),
        .done_o(sh_done_w), .rx_o(rx_w), .sclk_o(sclk_o), .cs_n_o(cs_n_w), .mosi_o(mosi_o)
    );

    assign cs_n_o = cs_n_w;
endmodule

// File: tb/sim_stpoll_top.sv
module sim_stpoll_top;
    localparam int HALF   = 1;
    localparam int MAXT   = 5;
    localparam int CSGAP  = 2;
    localparam logic [7:0] JUNK = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] mask = 8'h00;
    logic       done;
    logic [1:0] res;
    logic [7:0] status;
    logic       sclk, cs_n, mosi;
    logic       miso = 1'b0;

    int compared = 0;
    int mismatched = 0;

    // target script, written only by the stimulus process
    int         g_bn = 0;
    logic [7:0] g_bb = 8'h00;
    logic [7:0] g_fb = 8'h00;
    int         base = 0;

    // monitor state, written only by the target model
    int       txn_cnt = 0;
    int       edges = 0;
    bit       in_frame = 0;
    int       bad_frame = 0;
    int       bad_idle = 0;
    int       bad_mosi = 0;
    realtime  rise_t = 0;
    realtime  min_gap = 1.0e9;
    logic     cs_prev = 1'b1;
    logic     sclk_prev = 1'b0;
    logic [7:0] sh = 8'h00;

    always #2.5 clk = ~clk;

    stpoll_top #(.HALF(HALF), .MAX_TRIES(MAXT), .CS_GAP(CSGAP)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask),
        .done_o(done), .res_o(res), .status_o(status),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
    );

    function automatic logic [7:0] samp(int i);
        return (i < g_bn) ? g_bb : g_fb;
    endfunction

    // Mode-0 target model plus frame monitors
    always @(cs_n or sclk) begin
        if (cs_prev && !cs_n) begin
            int idx;
            idx = txn_cnt - base;
            sh = (idx % 2 == 0) ? JUNK : samp(idx / 2);
            miso = sh[7];
            txn_cnt++;
            edges = 0;
            in_frame = 1;
            if ($realtime - rise_t < min_gap) min_gap = $realtime - rise_t;
        end
        if (!cs_prev && cs_n) begin
            if (in_frame && edges != 8) bad_frame++;
            in_frame = 0;
            rise_t = $realtime;
        end
        if (!sclk_prev && sclk) begin
            edges++;
            if (cs_n) bad_idle++;
            if (mosi !== 1'b0) bad_mosi++;
        end
        if (sclk_prev && !sclk && !cs_n) begin
            sh = {sh[6:0], 1'b0};
            miso = sh[7];
        end
        cs_prev = cs_n;
        sclk_prev = sclk;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model computed from the requirements
    task automatic model(input logic [7:0] m, output int r, output logic [7:0] st, output int n);
        r = 2; st = 8'h00; n = MAXT;
        for (int i = 0; i < MAXT; i++) begin
            logic [7:0] b;
            b = samp(i);
            st = b;
            if (b[2] || b[3]) begin r = 1; n = i + 1; return; end
            if (!b[0] && (m == 0 || (b & m) != 0)) begin r = 0; n = i + 1; return; end
        end
    endtask

    task automatic poll(input logic [7:0] m, input int bn, input logic [7:0] bb,
                        input logic [7:0] fb, input bit poke, input string tag);
        int er, en, cyc;
        logic [7:0] es;
        bit seen;
        g_bn = bn; g_bb = bb; g_fb = fb;
        base = txn_cnt;
        model(m, er, es, en);
        @(negedge clk); start = 1'b1; mask = m;
        @(negedge clk); start = 1'b0; mask = 8'h00;
        seen = 0;
        for (cyc = 0; cyc < 3000; cyc++) begin
            if (poke && cyc == 30) begin start = 1'b1; mask = 8'h80; end
            if (poke && cyc == 31) begin start = 1'b0; mask = 8'h00; end
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        chk(seen, {tag, " R9 done seen"}, seen, 1);
        chk(res == er[1:0], {tag, " result R4/R6/R7/R8"}, res, er);
        chk(status == es, {tag, " status R9"}, status, es);
        chk(txn_cnt - base == 2 * en, {tag, " transactions R2/R5"}, txn_cnt - base, 2 * en);
        @(negedge clk);
        chk(!done, {tag, " done one cycle R9"}, done, 0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk) rst_n = 1'b1;
                @(negedge clk);
                // R11 reset state
                chk(cs_n == 1'b1, "R11 cs_n", cs_n, 1);
                chk(sclk == 1'b0, "R11 sclk", sclk, 0);
                chk(done == 1'b0, "R11 done", done, 0);
                chk(status == 8'h00, "R11 status", status, 0);
                chk(res == 2'd0, "R11 res", res, 0);

                // R4 R5 R6 R7 R8: sweep status byte against masks
                for (int b = 0; b < 64; b++) begin
                    poll(8'h00, 0, 8'h00, 8'(b), 0, "sweep m00");
                    poll(8'h02, 0, 8'h00, 8'(b), 0, "sweep m02");
                    poll(8'h22, 0, 8'h00, 8'(b), 0, "sweep m22");
                    poll(8'h80, 0, 8'h00, 8'(b), 0, "sweep m80");
                end
                // R5 R8 retry boundary: busy runs of 0..MAXT samples
                for (int k = 0; k <= MAXT; k++) poll(8'h02, k, 8'h03, 8'h02, 0, "busy run");
                // R4 error after busy
                poll(8'h00, 2, 8'h01, 8'h08, 0, "err after busy");
                // R10 stray start mid-poll must be ignored
                poll(8'h00, 2, 8'h01, 8'h40, 1, "R10 stray start");
                // R9 status holds after completion
                repeat (20) @(negedge clk);
                chk(status == 8'h40 && res == 2'd0, "R9 hold", status, 8'h40);
                // R1 R3 frame monitors
                chk(bad_frame == 0, "R1 eight edges per frame", bad_frame, 0);
                chk(bad_idle == 0, "R1 sclk low when deselected", bad_idle, 0);
                chk(bad_mosi == 0, "R1 opcode 0x00 on mosi", bad_mosi, 0);
                chk(min_gap >= CSGAP * 2 * HALF * 5.0, "R3 cs gap ns", int'(min_gap), CSGAP * 2 * HALF * 5);
            end
            begin
                repeat (190000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) chk(0, "watchdog", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule